// File: doc/BRIEF.md
# Warp Sector Coalescer

The coalescer takes one load request from a warp: a byte address for each of 32 lanes and a mask of the lanes that are active. Every lane reads one 4-byte word. Memory is served in aligned 32-byte sectors. The block groups the active lanes by sector and issues one memory transaction for each distinct sector. Each transaction carries two things: the sector's byte address, and a mask of the lanes it serves. A downstream return path uses that mask to deliver data to each lane, or to broadcast one value to several lanes.

The block produces one transaction per cycle. In each cycle it finds the lowest-numbered active lane that has not yet been served. It takes that lane's sector and serves every pending lane whose address falls in the same sector. The transaction port has a valid/ready handshake, so memory can stall the block. When the last lane has been served, a one-cycle completion pulse reports how many sectors were fetched and how many bytes that amounts to. After that pulse the block takes the next request.

Top module: `warp_sector_coalescer`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken on a cycle where both `req_valid` and `req_ready` are high. From the next cycle, `req_ready` stays low until the request completes.
- R2: A lane's sector index is its byte address shifted right by 5. Each transaction's `txn_sector_addr` is that index shifted left by 5, so its low 5 bits are zero. Every lane in its `txn_lanes` has an address inside that sector.
- R3: The number of transactions equals the number of distinct sectors touched by the active lanes. Some examples:
  - 32 consecutive words from byte 0 give 4.
  - 32 consecutive words from byte 8 give 5.
  - An 8-byte lane stride gives 8.
  - A 12-byte lane stride gives 12.
- R4: Each active lane (bit i of `req_mask` set, lane i = bits [32i+31:32i] of `req_addr`) appears in exactly one transaction's `txn_lanes` (bit i). An inactive lane appears in none, whatever its address.
- R5: Transactions are emitted in ascending order of the lowest lane index each one serves.
- R6: Changing which lane holds which address does not change the transaction count. Reversed and shuffled orders of the same addresses give the same count as the original order.
- R7: If all 32 lanes use the same address, exactly one transaction is issued, with `txn_lanes` all ones.
- R8: A request whose mask is all zero issues no transaction. It completes on the cycle after acceptance, with a count of 0.
- R9: `done_bytes` equals 32 times `done_sectors`.
- R10: While `txn_valid` is high and `txn_ready` is low, `txn_valid`, `txn_sector_addr` and `txn_lanes` hold their values into the next cycle.
- R11: Any uniform lane stride of 32 bytes or more gives 32 transactions, the maximum.
- R12: A warp where lanes 0–15 read consecutive words from byte 0, and lanes 16–31 read at a 256-byte stride starting at byte 4000, gives 18 transactions.
- R13: `done_valid` is a one-cycle pulse. It is raised on the first cycle in which no lane is pending. `req_ready` is high on the cycle that follows the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_addr | input | 1024 | Lane byte addresses; lane i in bits [32i+31:32i] |
| req_mask | input | 32 | Active-lane mask |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Memory accepts the transaction |
| txn_sector_addr | output | 32 | Byte address of the sector, 32-byte aligned |
| txn_lanes | output | 32 | Lanes served by this transaction |
| done_valid | output | 1 | One-cycle completion pulse |
| done_sectors | output | 6 | Number of sectors fetched for the request |
| done_bytes | output | 11 | Number of bytes fetched for the request |

## Verification
The assertions check the following on every cycle:
- The idle handshake.
- That transaction outputs stay stable under backpressure.
- That the completion pulse lasts one cycle and is followed by `req_ready`.
- That a handshaken lane mask is cleared from the pending set.
- That the lane picker grants at most one lane, and grants one whenever any lane is pending.

Some properties need a full request and a model of the sector set, so only the bench scenarios can show them:
- The distinct-sector count.
- The exact lane grouping and the emission order.
- Permutation invariance, broadcast, saturation and the mixed-pattern count of 18.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SCAN = 1'b1
    } phase_e;

endpackage

// File: rtl/wsc_lane_pick.sv
module wsc_lane_pick #(
    parameter int LANES = 32,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0] req_i,
    output logic [LANES-1:0] grant_o,
    output logic [IDX_W-1:0] idx_o
);

    logic [LANES:0] lower_seen;
    assign lower_seen[0] = 1'b0;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign grant_o[i]      = req_i[i] & ~lower_seen[i];
        assign lower_seen[i+1] = lower_seen[i] | req_i[i];
    end

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < LANES; i++) begin
            if (grant_o[i]) idx_o = idx_o | IDX_W'(i);
        end
    end

    // R5
    always_comb begin
        pick_onehot_chk: assert ($onehot0(grant_o));
    end

endmodule

// File: rtl/wsc_sector_match.sv
module wsc_sector_match #(
    parameter int LANES = 32,
    parameter int SEC_W = 27
) (
    input  logic [LANES*SEC_W-1:0] secs_i,
    input  logic [SEC_W-1:0]       key_i,
    output logic [LANES-1:0]       hit_o
);

    for (genvar i = 0; i < LANES; i++) begin : g_cmp
        assign hit_o[i] = (secs_i[i*SEC_W +: SEC_W] == key_i);
    end

endmodule

// File: rtl/warp_sector_coalescer.sv
module warp_sector_coalescer
    import wsc_pkg::*;
#(
    parameter int LANES        = 32,
    parameter int ADDR_W       = 32,
    parameter int SECTOR_BYTES = 32,
    localparam int SHIFT = $clog2(SECTOR_BYTES),
    localparam int SEC_W = ADDR_W - SHIFT,
    localparam int IDX_W = $clog2(LANES),
    localparam int CNT_W = $clog2(LANES + 1),
    localparam int BYT_W = CNT_W + SHIFT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]        req_mask,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_sector_addr,
    output logic [LANES-1:0]        txn_lanes,
    output logic                    done_valid,
    output logic [CNT_W-1:0]        done_sectors,
    output logic [BYT_W-1:0]        done_bytes
);

    typedef struct packed {
        phase_e                   phase;
        logic [LANES-1:0]         pend;
        logic [CNT_W-1:0]         cnt;
        logic [LANES*SEC_W-1:0]   secs;
    } state_t;

    state_t st_q, st_d;

    logic [LANES-1:0] grant;
    logic [IDX_W-1:0] pick_idx;
    logic [SEC_W-1:0] pick_sec;
    logic [LANES-1:0] hit;
    logic [LANES-1:0] served;
    logic             any_pend;

    wsc_lane_pick #(.LANES(LANES)) u_pick (
        .req_i   (st_q.pend),
        .grant_o (grant),
        .idx_o   (pick_idx)
    );

    assign pick_sec = st_q.secs[pick_idx*SEC_W +: SEC_W];

    wsc_sector_match #(.LANES(LANES), .SEC_W(SEC_W)) u_match (
        .secs_i (st_q.secs),
        .key_i  (pick_sec),
        .hit_o  (hit)
    );

    assign served   = hit & st_q.pend;
    assign any_pend = |st_q.pend;

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.phase = PH_SCAN;
                    st_d.pend  = req_mask;
                    st_d.cnt   = '0;
                    for (int i = 0; i < LANES; i++) begin
                        st_d.secs[i*SEC_W +: SEC_W] = req_addr[i*ADDR_W + SHIFT +: SEC_W];
                    end
                end
            end
            PH_SCAN: begin
                if (!any_pend) begin
                    st_d.phase = PH_IDLE;
                end else if (txn_ready) begin
                    st_d.pend = st_q.pend & ~served;
                    st_d.cnt  = st_q.cnt + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready       = (st_q.phase == PH_IDLE);
    assign txn_valid       = (st_q.phase == PH_SCAN) && any_pend;
    assign txn_sector_addr = {pick_sec, {SHIFT{1'b0}}};
    assign txn_lanes       = served;
    assign done_valid      = (st_q.phase == PH_SCAN) && !any_pend;
    assign done_sectors    = st_q.cnt;
    assign done_bytes      = {st_q.cnt, {SHIFT{1'b0}}};

    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    txn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=>
            (txn_valid && $stable(txn_sector_addr) && $stable(txn_lanes)));

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!done_valid && req_ready));

    // R4
    served_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_ready) |=> ((st_q.pend & $past(txn_lanes)) == '0));

    // R5
    grant_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ($countones(grant) == 1));

endmodule

// File: tb/sim_warp_sector_coalescer.sv
`timescale 1ns/1ps
module sim_warp_sector_coalescer;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1023:0] req_addr = '0;
    logic [31:0]   req_mask = '0;
    logic          txn_valid;
    logic          txn_ready = 1'b0;
    logic [31:0]   txn_sector_addr;
    logic [31:0]   txn_lanes;
    logic          done_valid;
    logic [5:0]    done_sectors;
    logic [10:0]   done_bytes;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] av [32];

    always #2 clk = ~clk;

    warp_sector_coalescer u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_mask(req_mask),
        .txn_valid(txn_valid), .txn_ready(txn_ready),
        .txn_sector_addr(txn_sector_addr), .txn_lanes(txn_lanes),
        .done_valid(done_valid), .done_sectors(done_sectors), .done_bytes(done_bytes)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic go(input string tag, input int exp_n, input logic [31:0] m, input int stall);
        logic [26:0] sq[$];
        logic [31:0] mq[$];
        logic [31:0] tmp;
        logic [31:0] seen = '0;
        int k = 0;
        bit rdy;
        for (int i = 0; i < 32; i++) begin
            if (m[i]) begin
                bit found = 0;
                for (int j = 0; j < sq.size(); j++) begin
                    if (sq[j] == av[i][31:5]) begin
                        tmp = mq[j]; tmp[i] = 1'b1; mq[j] = tmp; found = 1;
                    end
                end
                if (!found) begin
                    sq.push_back(av[i][31:5]);
                    mq.push_back(32'd1 << i);
                end
            end
        end
        chk(sq.size() == exp_n, tag, "model sector count", sq.size(), exp_n);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready while idle", req_ready, 1);
        for (int i = 0; i < 32; i++) req_addr[i*32 +: 32] = av[i];
        req_mask  = m;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R1", "ready after accept", req_ready, 0);
        forever begin
            if (sq.size() > 0) begin
                chk(txn_valid == 1'b1, "R3", "txn_valid", txn_valid, 1);
                chk(txn_sector_addr == {sq[0], 5'b0}, "R2", "sector addr (R5 order)",
                    txn_sector_addr, {sq[0], 5'b0});
                chk(txn_lanes == mq[0], "R4", "lane mask", txn_lanes, mq[0]);
                chk(done_valid == 1'b0, "R13", "done early", done_valid, 0);
                rdy = (stall == 0) || ((k % stall) == stall - 1);
                k++;
                txn_ready = rdy;
                @(negedge clk);
                if (rdy) begin
                    chk((seen & mq[0]) == 0, "R4", "lane served twice", seen & mq[0], 0);
                    seen = seen | mq[0];
                    void'(sq.pop_front());
                    void'(mq.pop_front());
                end
            end else begin
                txn_ready = 1'b0;
                chk(txn_valid == 1'b0, "R3", "extra txn", txn_valid, 0);
                chk(done_valid == 1'b1, "R13", "done pulse", done_valid, 1);
                chk(done_sectors == exp_n, tag, "done_sectors", done_sectors, exp_n);
                chk(done_bytes == 32 * exp_n, "R9", "done_bytes", done_bytes, 32 * exp_n);
                chk(seen == m, "R4", "lanes covered", seen, m);
                @(negedge clk);
                chk(done_valid == 1'b0, "R13", "pulse width", done_valid, 0);
                chk(req_ready == 1'b1, "R13", "ready after done", req_ready, 1);
                break;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b0 || req_ready == 1'b1, "R1", "ready known in reset", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
        chk(txn_valid == 1'b0, "R3", "reset txn_valid", txn_valid, 0);
        chk(done_valid == 1'b0, "R13", "reset done", done_valid, 0);

        for (int i = 0; i < 32; i++) av[i] = 32'(i * 4);
        go("R3", 4, 32'hFFFF_FFFF, 0);
        for (int i = 0; i < 32; i++) av[i] = 32'(8 + i * 4);
        go("R3", 5, 32'hFFFF_FFFF, 2);
        for (int i = 0; i < 32; i++) av[i] = 32'(i * 8);
        go("R3", 8, 32'hFFFF_FFFF, 0);
        for (int i = 0; i < 32; i++) av[i] = 32'(i * 12);
        go("R3", 12, 32'hFFFF_FFFF, 3);
        for (int i = 0; i < 32; i++) av[i] = 32'(i * 32);
        go("R11", 32, 32'hFFFF_FFFF, 0);
        for (int i = 0; i < 32; i++) av[i] = 32'h1000_0000 + 32'(i * 4096);
        go("R11", 32, 32'hFFFF_FFFF, 4);
        for (int i = 0; i < 32; i++) av[i] = 32'((31 - i) * 4);
        go("R6", 4, 32'hFFFF_FFFF, 0);
        for (int i = 0; i < 32; i++) av[i] = 32'(((i * 7) % 32) * 4);
        go("R6", 4, 32'hFFFF_FFFF, 2);
        for (int i = 0; i < 32; i++) av[i] = 32'h0000_ABC4;
        go("R7", 1, 32'hFFFF_FFFF, 3);
        for (int i = 0; i < 16; i++) av[i] = 32'(i * 4);
        for (int i = 16; i < 32; i++) av[i] = 32'(4000 + (i - 16) * 256);
        go("R12", 18, 32'hFFFF_FFFF, 0);
        for (int i = 0; i < 32; i++) av[i] = 32'(i * 64);
        go("R8", 0, 32'h0000_0000, 0);
        for (int i = 0; i < 32; i++) av[i] = (i[0]) ? 32'hDEAD_0000 + 32'(i * 32) : 32'(i * 4);
        go("R4", 4, 32'h5555_5555, 2);
        for (int i = 0; i < 32; i++) av[i] = 32'((i % 3) * 100 + (i / 3) * 4);
        go("R5", 6, 32'hF0F0_F0F3, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule